// File: doc/BRIEF.md
# System Tick Down-Counter Timer

This block is a periodic tick timer for a processor subsystem. It is built around a 24-bit counter that counts down by one on each tick. Software programs a reload value and sets an enable bit. The counter then counts down from the reload value. When it reaches zero, it raises a sticky wrap flag and, if interrupts are enabled, a one-cycle interrupt pulse. On the following tick it loads the reload value again.

Writing the current value register never loads a value. Whatever data is written, the counter and the wrap flag are both cleared. A cleared or freshly enabled counter spends one tick at zero and only then picks up the reload value. This gives a full first period after start.

Ticks come from one of two sources, chosen by a bit in the control register:
- every core clock cycle;
- a single-cycle tick-enable input driven by slower logic.

The register port is a plain synchronous request port: one access per cycle, no stalls. Read data returns one cycle after the request.

Top module: `systick_timer`

## Requirements
- R1: After reset the control, reload and current value registers all read zero, and `irq_o` and `rsp_valid_o` are low.
- R2: While enabled, each tick decrements a non-zero counter by one. A tick is every cycle when control bit 2 (core clock select) is 1, and only cycles with `tick_en_i` high when it is 0.
- R3: A tick that finds the counter at zero loads the reload value, so the counter spends one full tick at zero before counting down from the reload value.
- R4: A write to word address 2 (current value) sets the counter to zero and clears the wrap flag, whatever data is written. A tick in the same cycle is dropped.
- R5: The wrap flag, read at control bit 16, is set by a tick that moves the counter from 1 to 0. A read of word address 0 (control) returns it and then clears it. A flag set in the same cycle as the read is kept.
- R6: When control bit 1 (interrupt enable) is 1, `irq_o` is high for exactly one cycle, starting on the edge that sets the wrap flag. When control bit 1 is 0, `irq_o` stays low.
- R7: With a reload value of zero, the counter stays at zero and never sets the flag or raises `irq_o`.
- R8: Reads of word addresses 1 (reload) and 2 (current) return zero in bits 31..24, and data bits 31..24 written there are dropped. Word address 3 reads as zero.
- R9: While control bit 0 (enable) is 0, the counter holds its value, and no flag or interrupt is produced.
- R10: A read request returns its data on `rsp_rdata_o` with `rsp_valid_o` high in the cycle after the request. The data shows register state from before the request's clock edge.
- R11: In the control register only bits 0, 1 and 2 are writable. The flag bit 16 ignores writes, and all other bits read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en_i | input | 1 | External single-cycle tick, used when core clock select is 0 |
| req_valid_i | input | 1 | Register access request this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 2 | Word address: 0 control, 1 reload, 2 current value, 3 unused |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata_o | output | 32 | Read data |
| irq_o | output | 1 | One-cycle interrupt pulse on counter wrap |

## Verification
Counter updates, flag set and `irq_o` all take effect on the edge where the tick is sampled. A read sampled on edge k therefore shows the counter as it stood after edge k-1, and the bench compares it with its model state from before that edge's step. The bench drives inputs and samples outputs on the falling edge, so each value is checked half a cycle after the edge that produced it. Control writes take one edge to register, so the first tick after an enable write falls on the next edge. The bench model starts stepping from that edge.

// File: rtl/systick_pkg.sv
package systick_pkg;
  localparam int REG_CTRL    = 0;
  localparam int REG_RELOAD  = 1;
  localparam int REG_CURRENT = 2;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_IE_BIT   = 1;
  localparam int CTRL_CORE_BIT = 2;
  localparam int CTRL_FLAG_BIT = 16;

  typedef struct packed {
    logic clk_core;
    logic irq_en;
    logic enable;
  } ctrl_t;
endpackage

// File: rtl/systick_regs.sv
module systick_regs
  import systick_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2,
  parameter int CNT_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              flag_i,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic              cur_clear_o,
  output logic              flag_rd_clr_o,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(REG_CTRL);
  localparam logic [ADDR_W-1:0] A_RLD  = ADDR_W'(REG_RELOAD);
  localparam logic [ADDR_W-1:0] A_CUR  = ADDR_W'(REG_CURRENT);

  ctrl_t             ctrl_q;
  logic [CNT_W-1:0]  reload_q;
  logic [DATA_W-1:0] rd_mux;
  logic              wr_ctrl, wr_rld, rd_req;

  assign rd_req        = req_valid_i && !req_write_i;
  assign wr_ctrl       = req_valid_i && req_write_i && (req_addr_i == A_CTRL);
  assign wr_rld        = req_valid_i && req_write_i && (req_addr_i == A_RLD);
  assign cur_clear_o   = req_valid_i && req_write_i && (req_addr_i == A_CUR);
  assign flag_rd_clr_o = rd_req && (req_addr_i == A_CTRL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      reload_q <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.enable   <= req_wdata_i[CTRL_EN_BIT];
        ctrl_q.irq_en   <= req_wdata_i[CTRL_IE_BIT];
        ctrl_q.clk_core <= req_wdata_i[CTRL_CORE_BIT];
      end
      if (wr_rld) reload_q <= req_wdata_i[CNT_W-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (req_addr_i)
      A_CTRL: begin
        rd_mux[CTRL_EN_BIT]   = ctrl_q.enable;
        rd_mux[CTRL_IE_BIT]   = ctrl_q.irq_en;
        rd_mux[CTRL_CORE_BIT] = ctrl_q.clk_core;
        rd_mux[CTRL_FLAG_BIT] = flag_i;
      end
      A_RLD:   rd_mux[CNT_W-1:0] = reload_q;
      A_CUR:   rd_mux[CNT_W-1:0] = cnt_i;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= rd_req;
      if (rd_req) rsp_rdata_o <= rd_mux;
    end
  end

  assign ctrl_o   = ctrl_q;
  assign reload_o = reload_q;
endmodule

// File: rtl/systick_tickgen.sv
module systick_tickgen (
  input  logic enable_i,
  input  logic clk_core_i,
  input  logic tick_en_i,
  output logic tick_o
);
  assign tick_o = enable_i && (clk_core_i || tick_en_i);
endmodule

// File: rtl/systick_counter.sv
module systick_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             clear_i,
  input  logic             flag_clr_i,
  input  logic             irq_en_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             flag_o,
  output logic             irq_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             flag_q, irq_q, wrap;

  assign wrap = tick_i && !clear_i && (cnt_q == ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= wrap && irq_en_i;
      if (clear_i) begin
        cnt_q  <= '0;
        flag_q <= 1'b0;
      end else begin
        if (tick_i) begin
          if (cnt_q == '0) cnt_q <= reload_i;
          else             cnt_q <= cnt_q - ONE;
        end
        if (wrap)            flag_q <= 1'b1;
        else if (flag_clr_i) flag_q <= 1'b0;
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign flag_o = flag_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/systick_timer.sv
module systick_timer
  import systick_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2,
  parameter int CNT_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en_i,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              irq_o
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] reload, cnt;
  logic             cur_clear, flag_rd_clr, flag, tick;

  systick_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid_i  (req_valid_i),
    .req_write_i  (req_write_i),
    .req_addr_i   (req_addr_i),
    .req_wdata_i  (req_wdata_i),
    .cnt_i        (cnt),
    .flag_i       (flag),
    .ctrl_o       (ctrl),
    .reload_o     (reload),
    .cur_clear_o  (cur_clear),
    .flag_rd_clr_o(flag_rd_clr),
    .rsp_valid_o  (rsp_valid_o),
    .rsp_rdata_o  (rsp_rdata_o)
  );

  systick_tickgen u_tick (
    .enable_i  (ctrl.enable),
    .clk_core_i(ctrl.clk_core),
    .tick_en_i (tick_en_i),
    .tick_o    (tick)
  );

  systick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick),
    .clear_i   (cur_clear),
    .flag_clr_i(flag_rd_clr),
    .irq_en_i  (ctrl.irq_en),
    .reload_i  (reload),
    .cnt_o     (cnt),
    .flag_o    (flag),
    .irq_o     (irq_o)
  );
endmodule

// File: rtl/systick_timer_chk.sv
module systick_timer_chk
  import systick_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2,
  parameter int CNT_W  = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid_i,
  input logic              req_write_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic              rsp_valid_o,
  input logic [DATA_W-1:0] rsp_rdata_o,
  input logic              irq_o,
  input logic              tick,
  input logic              enable,
  input logic              cur_clear,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  reload,
  input logic              flag
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(REG_CTRL);
  localparam logic [ADDR_W-1:0] A_CUR  = ADDR_W'(REG_CURRENT);

  assert_dec_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cur_clear && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1)));

  assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cur_clear && cnt == '0) |=> (cnt == $past(reload)));

  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_write_i && req_addr_i == A_CUR) |=> (cnt == '0 && !flag));

  assert_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cur_clear && cnt == CNT_W'(1)) |=> flag);

  assert_irq_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> flag);

  assert_irq_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);

  assert_zero_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cur_clear && cnt == '0 && reload == '0) |=> (cnt == '0 && !irq_o));

  assert_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && $past(req_addr_i) != A_CTRL) |-> (rsp_rdata_o[DATA_W-1:CNT_W] == '0));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !cur_clear) |=> ($stable(cnt) && !irq_o));

  assert_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && !req_write_i) |=> rsp_valid_o);
endmodule

bind systick_timer systick_timer_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid_i(req_valid_i),
  .req_write_i(req_write_i),
  .req_addr_i (req_addr_i),
  .rsp_valid_o(rsp_valid_o),
  .rsp_rdata_o(rsp_rdata_o),
  .irq_o      (irq_o),
  .tick       (tick),
  .enable     (ctrl.enable),
  .cur_clear  (cur_clear),
  .cnt        (cnt),
  .reload     (reload),
  .flag       (flag)
);

// File: tb/systick_timer_tb.sv
module systick_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en_i = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_write_i = 1'b0;
  logic [1:0]  req_addr_i = '0;
  logic [31:0] req_wdata_i = '0;
  logic        rsp_valid_o;
  logic [31:0] rsp_rdata_o;
  logic        irq_o;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  systick_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en_i(tick_en_i),
    .req_valid_i(req_valid_i), .req_write_i(req_write_i),
    .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
    .rsp_valid_o(rsp_valid_o), .rsp_rdata_o(rsp_rdata_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Tasks start and end just after a falling edge.
  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    req_valid_i = 1'b1; req_write_i = 1'b1; req_addr_i = a; req_wdata_i = d;
    @(negedge clk);
    req_valid_i = 1'b0; req_write_i = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    req_valid_i = 1'b1; req_write_i = 1'b0; req_addr_i = a;
    @(negedge clk);
    req_valid_i = 1'b0;
    chk("R10 rsp_valid", {31'b0, rsp_valid_o}, 32'd1);
    d = rsp_rdata_o;
  endtask

  // Program, enable, and follow the counter cycle by cycle against a model.
  task automatic run_seq(input int rl, input logic [2:0] ctrl, input int n);
    logic [31:0] d;
    int s = 0;
    bit ef = 0;
    bit en = ctrl[0];
    bit ie = ctrl[1];
    bit core = ctrl[2];
    bus_write(2'd1, rl);
    bus_write(2'd2, 32'h00A5_A5A5);
    bus_write(2'd0, {29'b0, ctrl});
    for (int k = 1; k <= n; k++) begin
      bit te = core ? 1'b0 : (((k % 3) == 0) || ((k % 5) == 1));
      bit tk;
      tick_en_i = te;
      req_valid_i = 1'b1; req_write_i = 1'b0; req_addr_i = 2'd2;
      @(negedge clk);
      tk = en && (core || te);
      chk(!en ? "R9 hold" : (rl == 0 ? "R7 zero reload" : (s == 0 ? "R3 reload" : "R2 count")),
          rsp_rdata_o, s);
      chk("R6 irq", {31'b0, irq_o}, {31'b0, (tk && s == 1 && ie)});
      if (tk) begin
        if (s == 1) ef = 1;
        s = (s == 0) ? rl : s - 1;
      end
    end
    tick_en_i = 1'b0;
    req_valid_i = 1'b0;
    bus_write(2'd0, 32'd0);
    if (en && core) begin
      if (s == 1) ef = 1;
      s = (s == 0) ? rl : s - 1;
    end
    bus_read(2'd2, d);
    chk("R9 hold after disable", d, s);
    bus_read(2'd0, d);
    chk("R5 flag read", d, {15'b0, ef, 16'b0});
    bus_read(2'd0, d);
    chk("R5 flag cleared by read", d, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq", {31'b0, irq_o}, 32'd0);
    chk("R1 rsp_valid", {31'b0, rsp_valid_o}, 32'd0);
    for (int a = 0; a < 3; a++) begin
      bus_read(2'(a), d);
      chk("R1 reset value", d, 32'd0);
    end

    bus_write(2'd1, 32'hFFFF_FFFF);
    bus_read(2'd1, d);
    chk("R8 reload upper bits", d, 32'h00FF_FFFF);
    bus_write(2'd2, 32'hFFAB_CDEF);
    bus_read(2'd2, d);
    chk("R4 current write clears", d, 32'd0);
    bus_read(2'd3, d);
    chk("R8 unused address", d, 32'd0);
    bus_write(2'd0, 32'hFFFF_FFF6);
    bus_read(2'd0, d);
    chk("R11 control layout", d, 32'd6);
    bus_write(2'd0, 32'd0);

    // Disabled: counter holds, no irq
    run_seq(5, 3'b110, 10);
    run_seq(5, 3'b010, 10);
    // Sweep reload, interrupt enable and tick source
    for (int core = 0; core < 2; core++)
      for (int ie = 0; ie < 2; ie++)
        for (int rl = 0; rl < 6; rl++)
          run_seq(rl, {core[0], ie[0], 1'b1}, 3 * rl + 8);

    // R4: write to current mid-count clears counter and flag
    bus_write(2'd1, 32'd1);
    bus_write(2'd2, 32'd0);
    bus_write(2'd0, 32'd5);
    for (int k = 0; k < 3; k++) bus_read(2'd1, d);
    bus_write(2'd2, 32'h0012_3456);
    bus_write(2'd0, 32'd0);
    bus_read(2'd0, d);
    chk("R4 flag cleared by current write", d, 32'd0);
    bus_read(2'd2, d);
    chk("R4 reload one tick after clear", d, 32'd1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule